// File: doc/BRIEF.md
# Byte/Word Arithmetic-Logic Unit with Status Flags

The unit takes two operands, an operation code and a width select, and produces a result at either byte or word width. The result and the write-back indication are formed combinationally in the same cycle. A six-bit status register is updated on the clock edge whenever the operation changes status. The unit covers addition, subtraction, a compare that only sets status, bitwise AND, OR, XOR and invert, a status-only AND test, and a decimal correction step that follows the addition of two packed BCD bytes.

The status register holds carry, parity, auxiliary carry, zero, sign and overflow. The carry and auxiliary carry already in the register feed the decimal correction step, so a BCD addition is issued as an ADD followed by a correction on the sum. The byte width is a parameter, and a word is two bytes.

Top module: `alu_flags`

## Requirements
- R1: While reset is asserted (rst_n low), and after it is released, the status register `flags` reads 0. Bit order of `flags`: 0 carry, 1 parity, 2 auxiliary carry, 3 zero, 4 sign, 5 overflow.
- R2: The operation codes are 0 ADD and 1 SUB. With `wide` at 1 the width is 16 bits; with `wide` at 0 it is 8 bits, and the upper byte of `result` is 0. ADD gives a+b at that width. Carry is the carry out of the top bit. Overflow is set when both operands have the same sign and the result sign differs from it.
- R3: SUB (code 1) and CMP (code 2) give a−b at the selected width. Carry is set on a borrow. Overflow is set when the operand signs differ and the result sign differs from the sign of a. CMP drives the difference on `result` but keeps `wb` low.
- R4: The operation codes are 3 AND, 4 TEST, 5 OR and 6 XOR, and each gives its bitwise result. All four clear carry, overflow and auxiliary carry. TEST keeps `wb` low, and the other three raise it.
- R5: Parity is 1 when bits 7:0 of the result hold an even number of ones. This holds at word width too.
- R6: Zero is set when the result at the selected width is 0. Sign equals bit 7 (byte) or bit 15 (word) of the result.
- R7: Auxiliary carry is set, for ADD, SUB and CMP, on a carry out of or a borrow into bit 3.
- R8: Decimal adjust (code 8) works on the low byte of a, using the stored carry and auxiliary carry. Applied after an ADD of two packed BCD bytes x and y, it yields the BCD form of (x+y) mod 100. It sets carry when x+y ≥ 100, sets auxiliary carry when the low digits sum to 10 or more, clears overflow and raises `wb`.
- R9: NOT (code 7) drives the inverted a at the selected width, raises `wb` and leaves `flags` unchanged.
- R10: When `en` is low, `wb` is low and `flags` holds. Codes 9 to 15 keep `wb` low and leave `flags` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operation valid / status update enable |
| op | input | 4 | Operation code |
| wide | input | 1 | 1 selects word width, 0 byte width |
| a | input | 16 | Destination operand |
| b | input | 16 | Source operand |
| result | output | 16 | Combinational result |
| wb | output | 1 | Result should be written back |
| flags | output | 6 | Registered status |

## Verification
The bench builds the unit with its default 8-bit byte, which gives a 16-bit word. At that size every byte value of a can be paired with sixteen spread values of b for each byte-width operation. Every pair of two-digit BCD numbers can be run through ADD and then decimal adjust, so every correction path and every decimal carry is exercised. Word-width operations use a pseudo-random operand stream, and the reference status is derived with signed and unsigned integer arithmetic.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic [3:0]          op,
  input  logic                wide,
  input  logic [2*BYTE_W-1:0] a,
  input  logic [2*BYTE_W-1:0] b,
  output logic [2*BYTE_W-1:0] result,
  output logic                wb,
  output logic [5:0]          flags
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam logic [3:0] OP_ADD = 4'd0, OP_SUB = 4'd1, OP_CMP = 4'd2, OP_AND = 4'd3,
                         OP_TST = 4'd4, OP_OR = 4'd5, OP_XOR = 4'd6, OP_NOT = 4'd7,
                         OP_DAA = 4'd8;
  localparam int F_C = 0, F_P = 1, F_A = 2, F_Z = 3, F_S = 4, F_O = 5;

  logic [WORD_W:0] add_w, sub_w;
  logic [BYTE_W:0] add_b, sub_b;
  logic [WORD_W-1:0] mask, raw, rm;
  logic c_n, a_n, o_n, upd, is_add, is_sub;
  logic amsb, bmsb, rmsb;
  logic [BYTE_W-1:0] al, daa_r;
  logic [BYTE_W:0] daa_t;
  logic lo_adj, hi_adj;
  logic [5:0] nxt;

  assign add_w = {1'b0, a} + {1'b0, b};
  assign sub_w = {1'b0, a} - {1'b0, b};
  assign add_b = {1'b0, a[BYTE_W-1:0]} + {1'b0, b[BYTE_W-1:0]};
  assign sub_b = {1'b0, a[BYTE_W-1:0]} - {1'b0, b[BYTE_W-1:0]};
  assign mask  = wide ? '1 : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};

  assign al     = a[BYTE_W-1:0];
  assign lo_adj = (al[3:0] > 4'd9) || flags[F_A];
  assign hi_adj = (al > BYTE_W'(8'h99)) || flags[F_C];
  assign daa_t  = {1'b0, al} + (lo_adj ? (BYTE_W+1)'(6) : '0);
  assign daa_r  = daa_t[BYTE_W-1:0] + (hi_adj ? BYTE_W'(8'h60) : '0);

  assign is_add = (op == OP_ADD);
  assign is_sub = (op == OP_SUB) || (op == OP_CMP);

  always_comb begin
    raw = '0;
    c_n = 1'b0;
    unique case (op)
      OP_ADD:         begin raw = add_w[WORD_W-1:0]; c_n = wide ? add_w[WORD_W] : add_b[BYTE_W]; end
      OP_SUB, OP_CMP: begin raw = sub_w[WORD_W-1:0]; c_n = wide ? sub_w[WORD_W] : sub_b[BYTE_W]; end
      OP_AND, OP_TST: raw = a & b;
      OP_OR:          raw = a | b;
      OP_XOR:         raw = a ^ b;
      OP_NOT:         raw = ~a;
      OP_DAA:         begin raw = WORD_W'(daa_r); c_n = hi_adj; end
      default:        raw = '0;
    endcase
  end

  assign rm   = (op == OP_DAA) ? raw : (raw & mask);
  assign amsb = wide ? a[WORD_W-1] : a[BYTE_W-1];
  assign bmsb = wide ? b[WORD_W-1] : b[BYTE_W-1];
  assign rmsb = (wide && op != OP_DAA) ? rm[WORD_W-1] : rm[BYTE_W-1];

  assign a_n = (op == OP_DAA) ? lo_adj : ((is_add || is_sub) && (a[4] ^ b[4] ^ rm[4]));
  assign o_n = is_add ? ((amsb == bmsb) && (rmsb != amsb)) :
               is_sub ? ((amsb != bmsb) && (rmsb != amsb)) : 1'b0;

  assign nxt[F_C] = c_n;
  assign nxt[F_P] = ~^rm[BYTE_W-1:0];
  assign nxt[F_A] = a_n;
  assign nxt[F_Z] = (rm == '0);
  assign nxt[F_S] = rmsb;
  assign nxt[F_O] = o_n;

  assign upd    = en && (op <= OP_DAA) && (op != OP_NOT);
  assign wb     = en && (op <= OP_DAA) && (op != OP_CMP) && (op != OP_TST);
  assign result = rm;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   flags <= '0;
    else if (upd) flags <= nxt;

  p_cmp_test_no_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_CMP || op == OP_TST)) |-> !wb);
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en || op > OP_DAA) |=> $stable(flags));
  p_not_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_NOT) |=> $stable(flags));
  p_logic_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_TST))
    |=> (!flags[F_C] && !flags[F_O] && !flags[F_A]));
  p_parity_low_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_XOR) |=> (flags[F_P] == ~^$past(result[BYTE_W-1:0])));
  p_daa_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op == OP_DAA) |=> !flags[F_O]);
endmodule

// File: tb/alu_flags_test.sv
module alu_flags_test;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, wide = 1'b0;
  logic [3:0] op = 4'd0;
  logic [15:0] a = '0, b = '0;
  logic [15:0] result;
  logic wb;
  logic [5:0] flags;
  int checks = 0, errors = 0;
  logic [5:0] mf = '0;
  logic [15:0] er;
  logic ewb;
  logic [5:0] ef;
  logic eupd;
  logic [15:0] lfsr = 16'hACE1;

  alu_flags uut (.clk(clk), .rst_n(rst_n), .en(en), .op(op), .wide(wide), .a(a), .b(b),
                 .result(result), .wb(wb), .flags(flags));

  always #10 clk = ~clk;

  function automatic string rq(input logic [3:0] o);
    case (o)
      4'd0: return "R2";  4'd1, 4'd2: return "R3";
      4'd3, 4'd4, 4'd5, 4'd6: return "R4";
      4'd7: return "R9";  4'd8: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [3:0] o, input logic w, input logic [15:0] x, input logic [15:0] y);
    int lim = w ? 65536 : 256;
    int half = lim / 2;
    int xi = int'(x) % lim, yi = int'(y) % lim, s, sx, sy, ss, r;
    logic c = 0, ac = 0, ov = 0;
    sx = (xi >= half) ? xi - lim : xi;
    sy = (yi >= half) ? yi - lim : yi;
    r = 0;
    case (o)
      4'd0: begin s = xi + yi; r = s % lim; c = (s >= lim); ac = ((xi % 16) + (yi % 16)) >= 16;
              ss = sx + sy; ov = (ss >= half) || (ss < -half); end
      4'd1, 4'd2: begin r = (xi - yi + lim) % lim; c = (xi < yi); ac = (xi % 16) < (yi % 16);
              ss = sx - sy; ov = (ss >= half) || (ss < -half); end
      4'd3, 4'd4: r = xi & yi;
      4'd5: r = xi | yi;
      4'd6: r = xi ^ yi;
      4'd7: r = (~xi) & (lim - 1);
      default: r = 0;
    endcase
    er = 16'(r);
    ewb = en && (o <= 4'd8) && o != 4'd2 && o != 4'd4;
    eupd = en && (o <= 4'd8) && o != 4'd7;
    ef = {ov, (r >= half), (r == 0), ac, ~^er[7:0], c};
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run(input logic e, input logic [3:0] o, input logic w, input logic [15:0] x, input logic [15:0] y);
    @(negedge clk);
    en = e; op = o; wide = w; a = x; b = y;
    model(o, w, x, y);
    #2;
    if (o != 4'd8 && o <= 4'd8) chk(rq(o), "result", 32'(result), 32'(er));
    chk(e ? rq(o) : "R10", "wb", 32'(wb), 32'(ewb));
    @(posedge clk);
    @(negedge clk);
    if (eupd && o != 4'd8) mf = ef;
    if (o != 4'd8) chk(e ? rq(o) : "R10", "flags", 32'(flags), 32'(mf));
    en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1", "flags in reset", 32'(flags), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "flags after reset", 32'(flags), 32'd0);

    // R2 R3 R4 R9: byte sweep, all a, spread b
    for (int o = 0; o < 8; o++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y += 17)
          run(1'b1, 4'(o), 1'b0, 16'(x) | 16'hA500, 16'(y) | 16'h5A00);

    // word width, R5 R6 R7 with wide results
    for (int o = 0; o < 8; o++)
      for (int k = 0; k < 1000; k++) begin
        logic [15:0] x0;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        x0 = lfsr;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        run(1'b1, 4'(o), 1'b1, x0, (k % 50 == 0) ? x0 : lfsr);
      end

    // R6 word zero and sign corner cases
    run(1'b1, 4'd0, 1'b1, 16'h8000, 16'h8000);
    run(1'b1, 4'd1, 1'b1, 16'h7FFF, 16'hFFFF);
    run(1'b1, 4'd0, 1'b0, 16'h0080, 16'h0080);

    // R10: enable low and unused codes hold flags
    run(1'b1, 4'd1, 1'b1, 16'h0000, 16'h0001);
    run(1'b0, 4'd0, 1'b1, 16'h0000, 16'h0000);
    for (int o = 9; o < 16; o++) run(1'b1, 4'(o), 1'b1, 16'h1234, 16'h1234);

    // R8: all BCD pairs, ADD then decimal adjust
    for (int x = 0; x < 100; x++)
      for (int y = 0; y < 100; y++) begin
        logic [7:0] bx, by, s8, exr;
        int t;
        bx = 8'((x / 10) * 16 + x % 10);
        by = 8'((y / 10) * 16 + y % 10);
        run(1'b1, 4'd0, 1'b0, {8'h00, bx}, {8'h00, by});
        s8 = result[7:0];
        t = (x + y) % 100;
        exr = 8'((t / 10) * 16 + t % 10);
        run(1'b1, 4'd8, 1'b0, {8'h00, s8}, 16'h0000);
        mf = {1'b0, exr[7], exr == 8'h00, ((x % 10) + (y % 10)) >= 10, ~^exr, (x + y) >= 100};
        chk("R8", "daa result", 32'(result), 32'(exr));
        chk("R8", "daa flags", 32'(flags), 32'(mf));
      end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule